// File: doc/BRIEF.md
# Staged-Expiry Watchdog Timer

This block is a memory-mapped watchdog with its own tick timer. The timer divides a 1 MHz reference pulse train and sends one tick to the watchdog for each programmed number of reference pulses. It can run periodically or fire once. The watchdog counts down a programmed 8-bit period, one step per tick. Reaching the end of the period is an expiration. Each expiration reloads the countdown and advances a 2-bit expiration counter.

System reset is requested only when a fourth expiration occurs without an intervening refresh. An optional interrupt flags the first expiration, which gives software an early warning. Software refreshes the countdown by writing the start command. Stopping the watchdog needs a key write to a separate unlock register first, so a stray write cannot turn the watchdog off.

The bus is a simple strobe interface with a combinational read. Register offsets: config 0x00, status 0x04, command 0x08, unlock 0x0C, timer 0x10.

Top module: `stg_wdog`

## Requirements
- R1: After rst_ni is released, every register reads zero, irq_o and sys_rst_o are low, and the status register reads zero.
- R2: The config register at 0x00 holds the period in bits [11:4], interrupt-enable in bit 12 and reset-enable in bit 15. These read back as written, and all other bits read zero.
- R3: The timer register at 0x10 holds enable in bit 31, periodic in bit 30 and a reload value N in bits [TMR_W-1:0]. While enabled with N>0, the timer sends one tick for every N reference pulses. Writing this register restarts the pulse count. With N=0 or enable clear, no ticks are sent.
- R4: With periodic clear, the timer clears its own enable bit after its first tick.
- R5: Writing the command register at 0x08 with bit 0 set starts or refreshes the watchdog. This loads the countdown from the period and clears the expiration count. The status register at 0x04 shows the countdown in bits [11:4] and the expiration count in bits [13:12]. While the watchdog runs, each tick decrements the countdown.
- R6: A tick that arrives while the countdown is 1 or 0 is an expiration. It reloads the countdown from the period and increments the expiration count, which saturates at 3.
- R7: An expiration that arrives while the expiration count is 3, with reset-enable set, raises sys_rst_o. sys_rst_o then stays high until rst_ni is asserted. With reset-enable clear, no reset is raised.
- R8: If interrupt-enable is set, the first expiration raises irq_o. irq_o stays high until a start command or a disable clears it.
- R9: Command bit 1 disables the watchdog only if the most recent write to the unlock register at 0x0C was exactly 0x0000C45A. Otherwise the disable has no effect.
- R10: Any command write consumes the unlock, whether or not it disables.
- R11: While disabled, the watchdog ignores ticks. Its status countdown field shows the configured period and its expiration count shows 0.
- R12: If a single unlocked command write sets both bit 0 and bit 1, the disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle pulse from the 1 MHz reference |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of rd_en_i |
| irq_o | output | 1 | Early-warning interrupt |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
The assertions check several properties on every cycle:
- sys_rst_o stays set once it is set, and it can rise only out of an expiration count of 3.
- A start command leaves the watchdog running with a cleared expiration count and no interrupt.
- A disable without a pending unlock leaves the watchdog running.
- Every command write consumes the unlock.
- The interrupt rises only while interrupt-enable is set.

Only the bench scenarios can show the remaining behaviour:
- the exact tick arithmetic: division by the reload value, one-shot shutdown, and countdown and reload values;
- the exact expiration at which reset fires;
- the field positions of every register;
- that a disabled watchdog ignores ticks.

// File: rtl/stg_wdog_pkg.sv
package stg_wdog_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int PER_W  = 8;
  localparam int EXP_W  = 2;

  localparam logic [ADDR_W-1:0] OFF_CFG = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STS = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_UNL = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_TMR = 5'h10;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_C45A;

  localparam int PER_LSB  = 4;
  localparam int INT_BIT  = 12;
  localparam int RST_BIT  = 15;
  localparam int EXP_LSB  = 12;
  localparam int CMD_GO   = 0;
  localparam int CMD_HALT = 1;
  localparam int TMR_EN   = 31;
  localparam int TMR_PER  = 30;
endpackage

// File: rtl/stg_wdog_regs.sv
module stg_wdog_regs
  import stg_wdog_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PER_W-1:0]  sts_cnt_i,
  input  logic [EXP_W-1:0]  sts_exp_i,
  input  logic              tmr_off_i,
  output logic [PER_W-1:0]  period_o,
  output logic              int_en_o,
  output logic              rst_en_o,
  output logic              tmr_en_o,
  output logic              tmr_per_o,
  output logic [TMR_W-1:0]  tmr_reload_o,
  output logic              tmr_wr_o,
  output logic              go_o,
  output logic              halt_o,
  output logic              unlock_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_cmd;
  assign wr_cmd   = wr_en_i && (addr_i == OFF_CMD);
  assign tmr_wr_o = wr_en_i && (addr_i == OFF_TMR);
  assign go_o     = wr_cmd && wdata_i[CMD_GO];
  assign halt_o   = wr_cmd && wdata_i[CMD_HALT] && unlock_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o     <= '0;
      int_en_o     <= 1'b0;
      rst_en_o     <= 1'b0;
      tmr_en_o     <= 1'b0;
      tmr_per_o    <= 1'b0;
      tmr_reload_o <= '0;
      unlock_o     <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == OFF_CFG) begin
        period_o <= wdata_i[PER_LSB +: PER_W];
        int_en_o <= wdata_i[INT_BIT];
        rst_en_o <= wdata_i[RST_BIT];
      end
      if (wr_en_i && addr_i == OFF_UNL) unlock_o <= (wdata_i == UNLOCK_KEY);
      else if (wr_cmd)                  unlock_o <= 1'b0;
      if (tmr_wr_o) begin
        tmr_en_o     <= wdata_i[TMR_EN];
        tmr_per_o    <= wdata_i[TMR_PER];
        tmr_reload_o <= wdata_i[TMR_W-1:0];
      end else if (tmr_off_i) begin
        tmr_en_o <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        OFF_CFG: begin
          rdata_o[PER_LSB +: PER_W] = period_o;
          rdata_o[INT_BIT]          = int_en_o;
          rdata_o[RST_BIT]          = rst_en_o;
        end
        OFF_STS: begin
          rdata_o[PER_LSB +: PER_W] = sts_cnt_i;
          rdata_o[EXP_LSB +: EXP_W] = sts_exp_i;
        end
        OFF_TMR: begin
          rdata_o[TMR_EN]      = tmr_en_o;
          rdata_o[TMR_PER]     = tmr_per_o;
          rdata_o[TMR_W-1:0]   = tmr_reload_o;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stg_wdog_tick.sv
module stg_wdog_tick #(
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic [TMR_W-1:0] reload_i,
  input  logic             restart_i,
  output logic             tick_o,
  output logic             off_o
);
  logic [TMR_W-1:0] cnt_q;

  assign tick_o = en_i && ref_tick_i && (reload_i != '0) &&
                  (cnt_q == reload_i - TMR_W'(1));
  assign off_o  = tick_o && !periodic_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (en_i && ref_tick_i) cnt_q <= tick_o ? '0 : cnt_q + TMR_W'(1);
  end
endmodule

// File: rtl/stg_wdog_core.sv
module stg_wdog_core
  import stg_wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             int_en_i,
  input  logic             rst_en_i,
  output logic             running_o,
  output logic [PER_W-1:0] cnt_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             irq_o,
  output logic             sys_rst_o
);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  logic [PER_W-1:0] cnt_q;
  logic             expire;

  assign expire = tick_i && (cnt_q <= PER_W'(1));
  assign cnt_o  = running_o ? cnt_q : period_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_o <= 1'b0;
      cnt_q     <= '0;
      exp_o     <= '0;
      irq_o     <= 1'b0;
      sys_rst_o <= 1'b0;
    end else if (halt_i) begin
      running_o <= 1'b0;
      exp_o     <= '0;
      irq_o     <= 1'b0;
    end else if (go_i) begin
      running_o <= 1'b1;
      cnt_q     <= period_i;
      exp_o     <= '0;
      irq_o     <= 1'b0;
    end else if (running_o && tick_i) begin
      if (expire) begin
        cnt_q <= period_i;
        if (exp_o != EXP_MAX) exp_o <= exp_o + EXP_W'(1);
        if (exp_o == '0 && int_en_i) irq_o <= 1'b1;
        if (exp_o == EXP_MAX && rst_en_i) sys_rst_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - PER_W'(1);
      end
    end
  end
endmodule

// File: rtl/stg_wdog.sv
module stg_wdog
  import stg_wdog_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic [PER_W-1:0] period, sts_cnt;
  logic [EXP_W-1:0] sts_exp;
  logic             int_en, rst_en, tmr_en, tmr_per, tmr_wr, tmr_off;
  logic             go, halt, unlock, tick, running;
  logic [TMR_W-1:0] tmr_reload;

  stg_wdog_regs #(.TMR_W(TMR_W)) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .sts_cnt_i(sts_cnt), .sts_exp_i(sts_exp), .tmr_off_i(tmr_off),
    .period_o(period), .int_en_o(int_en), .rst_en_o(rst_en),
    .tmr_en_o(tmr_en), .tmr_per_o(tmr_per), .tmr_reload_o(tmr_reload),
    .tmr_wr_o(tmr_wr), .go_o(go), .halt_o(halt), .unlock_o(unlock),
    .rdata_o
  );

  stg_wdog_tick #(.TMR_W(TMR_W)) tick_i (
    .clk_i, .rst_ni, .ref_tick_i, .en_i(tmr_en), .periodic_i(tmr_per),
    .reload_i(tmr_reload), .restart_i(tmr_wr), .tick_o(tick), .off_o(tmr_off)
  );

  stg_wdog_core core_i (
    .clk_i, .rst_ni, .go_i(go), .halt_i(halt), .tick_i(tick),
    .period_i(period), .int_en_i(int_en), .rst_en_i(rst_en),
    .running_o(running), .cnt_o(sts_cnt), .exp_o(sts_exp),
    .irq_o, .sys_rst_o
  );
endmodule

// File: rtl/stg_wdog_chk.sv
module stg_wdog_chk
  import stg_wdog_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              unlock_i,
  input logic              running_i,
  input logic [EXP_W-1:0]  exp_i,
  input logic              int_en_i,
  input logic              irq_i,
  input logic              sys_rst_i
);
  logic cmd_wr;
  assign cmd_wr = wr_en_i && (addr_i == OFF_CMD);

  assert_rst_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> sys_rst_i);

  assert_rst_needs_exp3_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_i) |-> $past(exp_i) == '1);

  assert_go_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[CMD_GO] && !(wdata_i[CMD_HALT] && unlock_i))
      |=> (running_i && exp_i == '0 && !irq_i));

  assert_locked_halt_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[CMD_HALT] && !unlock_i && running_i) |=> running_i);

  assert_unlock_consumed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> !unlock_i);

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(int_en_i));
endmodule

bind stg_wdog stg_wdog_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .unlock_i(unlock), .running_i(running), .exp_i(sts_exp),
  .int_en_i(int_en), .irq_i(irq_o), .sys_rst_i(sys_rst_o)
);

// File: tb/stg_wdog_tb_top.sv
module stg_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sys_rst;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  localparam logic [31:0] CFG_INT = 32'h1000;
  localparam logic [31:0] CFG_RST = 32'h8000;
  localparam logic [31:0] KEY     = 32'h0000_C45A;

  always #2 clk = ~clk;

  stg_wdog #(.TMR_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .sys_rst_o(sys_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  function automatic logic [31:0] sts(input int cnt, input int exp);
    return (32'(exp) << 12) | (32'(cnt) << 4);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(5'h00, d); check("R1 cfg", d, 0);
    rd(5'h04, d); check("R1 status", d, 0);
    rd(5'h10, d); check("R1 timer", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 sys_rst", {31'b0, sys_rst}, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    do_reset();
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, d); check("R2 cfg all ones", d, 32'h0000_9FF0);
    wr(5'h00, 32'h0000_0A50); rd(5'h00, d); check("R2 cfg value", d, 32'h0000_0A50);
  endtask

  task automatic t_countdown();
    logic [31:0] d;
    do_reset();
    wr(5'h10, 32'hC000_0001);
    wr(5'h00, 32'h30);
    wr(5'h08, 32'h1);
    rd(5'h04, d); check("R5 loaded", d, sts(3, 0));
    pulses(1); rd(5'h04, d); check("R5 decrement", d, sts(2, 0));
  endtask

  task automatic t_stages(input bit rst_on);
    logic [31:0] d;
    do_reset();
    wr(5'h10, 32'hC000_0001);
    wr(5'h00, (2 << 4) | CFG_INT | (rst_on ? CFG_RST : 0));
    wr(5'h08, 32'h1);
    pulses(2); rd(5'h04, d); check("R6 first expiration", d, sts(2, 1));
    check("R8 irq on first", {31'b0, irq}, 1);
    pulses(4); rd(5'h04, d); check("R6 third expiration", d, sts(2, 3));
    check("R7 no reset before fourth", {31'b0, sys_rst}, 0);
    pulses(2); rd(5'h04, d); check("R6 saturate", d, sts(2, 3));
    check("R7 reset on fourth", {31'b0, sys_rst}, {31'b0, rst_on});
    wr(5'h08, 32'h1);
    check("R7 sticky after restart", {31'b0, sys_rst}, {31'b0, rst_on});
    check("R8 irq cleared by start", {31'b0, irq}, 0);
    rd(5'h04, d); check("R5 start clears exp", d, sts(2, 0));
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    do_reset();
    wr(5'h10, 32'hC000_0001);
    wr(5'h00, (5 << 4) | CFG_INT);
    wr(5'h08, 32'h1);
    wr(5'h08, 32'h2);
    pulses(1); rd(5'h04, d); check("R9 locked halt ignored", d, sts(4, 0));
    wr(5'h0C, 32'h0001_C45A);
    wr(5'h08, 32'h2);
    pulses(1); rd(5'h04, d); check("R9 wrong key ignored", d, sts(3, 0));
    wr(5'h0C, KEY);
    wr(5'h08, 32'h1);
    wr(5'h08, 32'h2);
    pulses(1); rd(5'h04, d); check("R10 unlock consumed", d, sts(4, 0));
    pulses(4); check("R8 irq before halt", {31'b0, irq}, 1);
    wr(5'h0C, KEY);
    wr(5'h08, 32'h2);
    rd(5'h04, d); check("R11 halted status", d, sts(5, 0));
    check("R8 irq cleared by halt", {31'b0, irq}, 0);
    pulses(7); rd(5'h04, d); check("R11 ticks ignored", d, sts(5, 0));
    wr(5'h00, 7 << 4);
    rd(5'h04, d); check("R11 shows period", d, sts(7, 0));
    wr(5'h08, 32'h1);
    wr(5'h0C, KEY);
    wr(5'h08, 32'h3);
    pulses(1); rd(5'h04, d); check("R12 halt beats start", d, sts(7, 0));
  endtask

  task automatic t_timer();
    logic [31:0] d;
    do_reset();
    wr(5'h00, 5 << 4);
    wr(5'h08, 32'h1);
    wr(5'h10, 32'hC000_0003);
    pulses(2); rd(5'h04, d); check("R3 divide no tick yet", d, sts(5, 0));
    pulses(1); rd(5'h04, d); check("R3 divide tick", d, sts(4, 0));
    wr(5'h10, 32'hC000_0000);
    pulses(3); rd(5'h04, d); check("R3 zero reload", d, sts(4, 0));
    wr(5'h10, 32'h4000_0001);
    pulses(2); rd(5'h04, d); check("R3 disabled timer", d, sts(4, 0));
    wr(5'h10, 32'h8000_0001);
    pulses(1); rd(5'h04, d); check("R4 one-shot tick", d, sts(3, 0));
    rd(5'h10, d); check("R4 enable cleared", d, 32'h0000_0001);
    pulses(2); rd(5'h04, d); check("R4 no more ticks", d, sts(3, 0));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cfg();
    t_countdown();
    t_stages(1'b1);
    t_stages(1'b0);
    t_unlock();
    t_timer();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule